// File: doc/BRIEF.md
# I2C Slave Transmit Buffer

This block is the sending half of an I2C slave. A host writes one byte at a time into a holding register. When the slave has been addressed for a read, or the master has acknowledged the previous byte, the held byte moves into a shift register on the next SCL falling edge. The byte then goes out on SDA most significant bit first. Both bus pins are open-drain: the block only ever asks for a line to be pulled low and otherwise releases it to the external pull-up. Inputs are SCL and SDA already synchronised to `clk`. Address recognition is outside this block, and a one-cycle `addr_hit` strobe from the surrounding slave starts a read transfer.

Clock stretching is optional. With it disabled, the host has one SCL period after the empty flag rises to supply the next byte; if it does not, the old holding contents go out again. With it enabled and nothing held, the block holds SCL low until the host writes. A byte that is already held when the load edge arrives is sent at once, without any stretch, even if it is stale. Two further controls can invalidate the holding register. One is a clear that acts when its bit is written 1 and then 0. The other is an asynchronous-address-detection enable: writes are ignored while it is set, and whatever was held is discarded when it drops.

Top module: `i2cs_tx_buf`

## Requirements
- R1: Synchronous reset sets `empty`=1, `sda_low`=0, `scl_low`=0 and `cur_byte`=0.
- R2: After `addr_hit`, or after a master ACK, the first SCL falling edge loads a byte into the shift register and shows it on `cur_byte`. Bit 7 is driven first, and each following SCL falling edge presents the next lower bit (`sda_low`=1 means a 0 bit).
- R3: `empty` goes to 1 when the held byte moves into the shift register. An accepted write sets it to 0.
- R4: A write while an unsent byte is held replaces that byte.
- R5: With `stretch_en`=0, a load with no new write sends the previous holding contents again.
- R6: With `stretch_en`=1 and nothing held at the load edge, `scl_low` is set from that edge until a write arrives. The written byte is loaded in that write's cycle, and `scl_low` clears on the next clock.
- R7: With `stretch_en`=1 and a byte held at the load edge, the byte is sent at once and `scl_low` stays 0.
- R8: Writing `buf_clr` to 1 and then to 0 zeroes the holding register and sets `empty`=1. Writing 1 alone has no effect.
- R9: While `async_det_en`=1, writes are ignored. When it returns to 0, the held byte is zeroed and `empty`=1.
- R10: The pins are drive-low only. `sda_low` changes only while SCL is low, and it is 0 during the ACK bit slot.
- R11: A master ACK (SDA=0 at the ninth SCL rise) continues with the next byte. A NACK ends the transfer with SDA released, and later SCL edges move no data until the next `addr_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| addr_hit | input | 1 | One-cycle strobe: slave addressed for a read |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DW | Host write data |
| stretch_en | input | 1 | Enable clock stretching |
| buf_clr | input | 1 | Clear control; acts on a 1 then 0 sequence |
| async_det_en | input | 1 | Asynchronous address detection enable |
| sda_low | output | 1 | Pull SDA low when 1, release when 0 |
| scl_low | output | 1 | Pull SCL low (stretch) when 1 |
| empty | output | 1 | Holding register has no unsent byte |
| cur_byte | output | DW | Byte most recently loaded for sending |

## Verification
A table of bytes is first sent back to back with ACKs between them: 10100101, 00111100, all ones, all zeros, and a final pattern closed by a NACK. This set separates bit order, stuck levels and shift-step errors. Directed sequences then cover the situations that only the load-edge decision can tell apart: a stale resend with no new write, an overwrite before the load, a load with stretching and nothing held, and a load with stretching and a held byte. The half-done and complete clear sequences are checked separately, as is a write hidden by the detection enable. In each case the serial bits, `empty` and `scl_low` are observed at the ports.

// File: rtl/i2cs_tx_pkg.sv
package i2cs_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOADW,
    ST_STRETCH,
    ST_SHIFT,
    ST_ACKW
  } txst_t;
endpackage

// File: rtl/i2cs_tx_hold.sv
// Holding register with write, two-step clear and detection-enable invalidation.
module i2cs_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ok,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_ctl,
  input  logic          async_en,
  input  logic          take,
  input  logic          consume,
  output logic [DW-1:0] buf_data,
  output logic          held
);
  logic clr_q, async_q, wipe;

  // clear fires on the 1 -> 0 step of either control
  assign wipe = (clr_q && !clr_ctl) || (async_q && !async_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data <= '0;
      held     <= 1'b0;
      clr_q    <= 1'b0;
      async_q  <= 1'b0;
    end else begin
      clr_q   <= clr_ctl;
      async_q <= async_en;
      if (wipe) begin
        buf_data <= '0;
        held     <= 1'b0;
      end else if (wr_ok) begin
        buf_data <= wr_data;
        held     <= !consume;   // consumed at once while stretching
      end else if (take) begin
        held     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cs_tx_shift.sv
// Load decision, MSB-first shifter, ACK slot and stretch control.
module i2cs_tx_shift
  import i2cs_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_fall,
  input  logic          scl_rise,
  input  logic          sda_in,
  input  logic          addr_hit,
  input  logic          stretch_en,
  input  logic [DW-1:0] buf_data,
  input  logic          held,
  input  logic          wr_ok,
  input  logic [DW-1:0] wr_data,
  output logic          take,
  output logic          consume,
  output logic          sda_low,
  output logic          scl_low,
  output logic [DW-1:0] tx_byte
);
  localparam int CW = $clog2(DW);

  txst_t         st;
  logic [DW-2:0] rest;
  logic [CW-1:0] cnt;

  assign take    = (st == ST_LOADW) && scl_fall && (held || !stretch_en);
  assign consume = (st == ST_STRETCH) && wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rest    <= '0;
      cnt     <= '0;
      sda_low <= 1'b0;
      scl_low <= 1'b0;
      tx_byte <= '0;
    end else begin
      case (st)
        ST_IDLE: if (addr_hit) st <= ST_LOADW;
        ST_LOADW: if (scl_fall) begin
          if (take) begin
            rest    <= buf_data[DW-2:0];
            tx_byte <= buf_data;
            sda_low <= !buf_data[DW-1];
            cnt     <= '0;
            st      <= ST_SHIFT;
          end else begin
            scl_low <= 1'b1;
            st      <= ST_STRETCH;
          end
        end
        ST_STRETCH: if (wr_ok) begin
          rest    <= wr_data[DW-2:0];
          tx_byte <= wr_data;
          sda_low <= !wr_data[DW-1];
          cnt     <= '0;
          scl_low <= 1'b0;
          st      <= ST_SHIFT;
        end
        ST_SHIFT: if (scl_fall) begin
          if (cnt == CW'(DW-1)) begin
            sda_low <= 1'b0;          // release for the ACK slot
            st      <= ST_ACKW;
          end else begin
            sda_low <= !rest[DW-2];
            rest    <= {rest[DW-3:0], 1'b0};
            cnt     <= cnt + 1'b1;
          end
        end
        ST_ACKW: if (scl_rise) st <= sda_in ? ST_IDLE : ST_LOADW;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_tx_buf.sv
module i2cs_tx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          addr_hit,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stretch_en,
  input  logic          buf_clr,
  input  logic          async_det_en,
  output logic          sda_low,
  output logic          scl_low,
  output logic          empty,
  output logic [DW-1:0] cur_byte
);
  logic          scl_q, scl_fall, scl_rise, wr_ok, take, consume, held;
  logic [DW-1:0] buf_data;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_in;
  end

  assign scl_fall = scl_q && !scl_in;
  assign scl_rise = !scl_q && scl_in;
  assign wr_ok    = wr_en && !async_det_en;
  assign empty    = !held;

  i2cs_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_data(wr_data),
    .clr_ctl(buf_clr), .async_en(async_det_en), .take(take),
    .consume(consume), .buf_data(buf_data), .held(held)
  );

  i2cs_tx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .scl_fall(scl_fall), .scl_rise(scl_rise),
    .sda_in(sda_in), .addr_hit(addr_hit), .stretch_en(stretch_en),
    .buf_data(buf_data), .held(held), .wr_ok(wr_ok), .wr_data(wr_data),
    .take(take), .consume(consume), .sda_low(sda_low), .scl_low(scl_low),
    .tx_byte(cur_byte)
  );
endmodule

// File: rtl/i2cs_tx_chk.sv
module i2cs_tx_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic wr_en,
  input logic async_det_en,
  input logic sda_low,
  input logic scl_low,
  input logic empty
);
  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low) |-> !$past(scl_in));
  // R10
  stretch_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_low) |-> !$past(scl_in));
  // R6
  stretch_release_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_low && wr_en && !async_det_en) |=> !scl_low);
  // R6
  stretch_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_low) |-> empty);
  // R3
  empty_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(empty) |-> $past(wr_en));
endmodule

bind i2cs_tx_buf i2cs_tx_chk u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .wr_en(wr_en),
  .async_det_en(async_det_en), .sda_low(sda_low), .scl_low(scl_low),
  .empty(empty)
);

// File: tb/i2cs_tx_buf_test.sv
module i2cs_tx_buf_test;
  localparam int DW = 8;
  localparam int NV = 5;
  // {ack_bit, byte}: ack 0 = ACK, 1 = NACK
  localparam logic [8:0] VEC [NV] = '{9'h0A5, 9'h03C, 9'h0FF, 9'h000, 9'h181};

  logic clk = 1'b0, rst = 1'b1;
  logic scl_in = 1'b1, sda_in = 1'b1, addr_hit = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic stretch_en = 1'b0, buf_clr = 1'b0, async_det_en = 1'b0;
  logic sda_low, scl_low, empty;
  logic [DW-1:0] cur_byte;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2cs_tx_buf #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .addr_hit(addr_hit),
    .wr_en(wr_en), .wr_data(wr_data), .stretch_en(stretch_en), .buf_clr(buf_clr),
    .async_det_en(async_det_en), .sda_low(sda_low), .scl_low(scl_low),
    .empty(empty), .cur_byte(cur_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_scl(input logic v);
    scl_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write(input logic [DW-1:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hit();
    addr_hit = 1'b1;
    @(negedge clk);
    addr_hit = 1'b0;
  endtask

  task automatic ack_slot(input logic ackv);
    set_scl(1'b0);
    check("R10 SDA released in ACK slot", sda_low, 0);
    sda_in = ackv;
    set_scl(1'b1);
    sda_in = 1'b1;
  endtask

  task automatic send(input logic ackv, output logic [DW-1:0] got);
    for (int i = DW - 1; i >= 0; i--) begin
      set_scl(1'b0);
      got[i] = ~sda_low;
      if (i == DW - 1) begin
        check("R3 empty after load", empty, 1);
        check("R7 no stretch with byte held", scl_low, 0);
      end
      set_scl(1'b1);
    end
    ack_slot(ackv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", empty, 1);
    check("R1 sda_low", sda_low, 0);
    check("R1 scl_low", scl_low, 0);
    check("R1 cur_byte", cur_byte, 0);

    // R2 table of bytes, ACK between them, NACK at the end
    for (int v = 0; v < NV; v++) begin
      write(VEC[v][7:0]);
      check("R3 write clears empty", empty, 0);
      if (v == 0) hit();
      send(VEC[v][8], got);
      check("R2 serial byte", got, VEC[v][7:0]);
      check("R2 cur_byte", cur_byte, VEC[v][7:0]);
    end

    // R11 after NACK no data moves
    write(8'h12);
    set_scl(1'b0); set_scl(1'b1); set_scl(1'b0);
    check("R11 SDA released after NACK", sda_low, 0);
    check("R11 held byte not taken", empty, 0);
    check("R11 cur_byte unchanged", cur_byte, 8'h81);
    set_scl(1'b1);

    // R8 clear sequence
    buf_clr = 1'b1; @(negedge clk); @(negedge clk);
    check("R8 write of 1 alone", empty, 0);
    buf_clr = 1'b0; @(negedge clk); @(negedge clk);
    check("R8 clear after 1 then 0", empty, 1);

    // R6 stretch with nothing held
    stretch_en = 1'b1;
    hit();
    set_scl(1'b0);
    check("R6 SCL held low", scl_low, 1);
    repeat (5) @(negedge clk);
    check("R6 SCL still held", scl_low, 1);
    write(8'h96);
    check("R6 SCL released", scl_low, 0);
    check("R6 byte loaded", cur_byte, 8'h96);
    check("R6 first bit", sda_low, 0);
    got[7] = ~sda_low;
    set_scl(1'b1);
    for (int i = 6; i >= 0; i--) begin
      set_scl(1'b0); got[i] = ~sda_low; set_scl(1'b1);
    end
    ack_slot(1'b0);
    check("R6 serial byte", got, 8'h96);

    // R7 held byte goes out at once with stretching on
    write(8'h5A);
    send(1'b1, got);
    check("R7 serial byte", got, 8'h5A);
    check("R7 scl_low", scl_low, 0);
    stretch_en = 1'b0;

    // R8 clear zeroes contents
    write(8'h77);
    buf_clr = 1'b1; @(negedge clk);
    buf_clr = 1'b0; @(negedge clk);
    hit();
    send(1'b1, got);
    check("R8 cleared byte sent as zero", got, 8'h00);

    // R9 detection enable
    write(8'h33);
    async_det_en = 1'b1; @(negedge clk);
    write(8'h44);
    check("R9 write ignored while enabled", empty, 0);
    async_det_en = 1'b0; @(negedge clk); @(negedge clk);
    check("R9 held byte invalidated", empty, 1);
    hit();
    send(1'b1, got);
    check("R9 invalid byte sent as zero", got, 8'h00);

    // R4 overwrite
    write(8'h11);
    write(8'h22);
    hit();
    send(1'b1, got);
    check("R4 overwrite", got, 8'h22);

    // R5 stale resend without stretching
    write(8'hC3);
    hit();
    send(1'b0, got);
    check("R5 first byte", got, 8'hC3);
    send(1'b1, got);
    check("R5 stale resend", got, 8'hC3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule